// File: doc/BRIEF.md
# Shared PC Update and Address Adder

This block holds the program counter and a single adder that serves two jobs. In the normal step, the adder adds the instruction size (4 bytes) to the PC, and the PC loads the result. In a PC-relative load, the same adder adds the sign-extended 16-bit offset field to the PC instead. The result goes into the memory address register in one clock cycle, so no second adder and no ALU pass is needed.

An operand select input picks the second adder input: the constant step or the extended offset. Two separate load enables send the sum to the PC or to the address register. The surrounding control sequence updates the PC first, in the decode step. A later offset addition therefore sees the already incremented PC, and the data address is (PC+4) + sext(offset). Reset is synchronous and clears both registers. The adder wraps modulo 2^32 and has no overflow flag.

Top module: `pc_addr_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` and `mar_q` both become 0 at that edge, whatever the other inputs are.
- R2: With `pc_ld`=1 and `use_offset`=0, `pc_q` becomes `pc_q`+4 at the next rising edge.
- R3: With `mar_ld`=1, `pc_ld`=0 and `use_offset`=1, `mar_q` becomes `pc_q` + sext(`ir_offset`) at the next rising edge, and `pc_q` is unchanged.
- R4: `ir_offset` is a two's-complement value: bit 15 is copied into bits 31:16 before the addition, so an offset with bit 15 set lowers the sum.
- R5: With both `pc_ld`=0 and `mar_ld`=0, `pc_q` and `mar_q` keep their values, whatever `use_offset` and `ir_offset` are.
- R6: With `pc_ld`=1 and `mar_ld`=1 together, the PC loads the sum and `mar_q` keeps its value.
- R7: The sum wraps modulo 2^32: 0xFFFFFFFC + 4 gives 0, and 0 + sext(0xFFFF) gives 0xFFFFFFFF.
- R8: With `pc_ld`=1 and `use_offset`=1, `pc_q` becomes `pc_q` + sext(`ir_offset`) at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_ld | input | 1 | Load the adder sum into the PC |
| mar_ld | input | 1 | Load the adder sum into the address register (ignored when `pc_ld` is high) |
| use_offset | input | 1 | Second adder operand: 0 selects the constant 4, 1 selects the sign-extended offset |
| ir_offset | input | 16 | Offset field taken from the instruction register |
| pc_q | output | 32 | Program counter |
| mar_q | output | 32 | Memory address register |

## Verification
The stimulus is a sequence of PC steps by 4, followed by address computations with small positive offsets, negative offsets and the largest positive offset. Comparing these results separates a correct sign extension from zero extension, and shows whether the offset is added to the already incremented PC. Idle cycles with changing offsets show whether either register loads without an enable. Cycles with both enables high show whether the address register obeys the PC-priority rule. A PC placed at 0xFFFFFFFC, stepped once, and then given an all-ones offset checks that the sum wraps instead of saturating or carrying out.

// File: rtl/pc_addr_unit.sv
module pc_addr_unit #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pc_ld,
  input  logic             mar_ld,
  input  logic             use_offset,
  input  logic [OFS_W-1:0] ir_offset,
  output logic [XLEN-1:0]  pc_q,
  output logic [XLEN-1:0]  mar_q
);
  localparam int EXT_W = XLEN - OFS_W;

  logic [XLEN-1:0] ofs_ext;
  logic [XLEN-1:0] operand;
  logic [XLEN-1:0] sum;
  logic            mar_we;

  assign ofs_ext = {{EXT_W{ir_offset[OFS_W-1]}}, ir_offset};
  assign operand = use_offset ? ofs_ext : XLEN'(STEP);
  assign sum     = pc_q + operand;
  assign mar_we  = mar_ld & ~pc_ld;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
    end else begin
      if (pc_ld)  pc_q  <= sum;
      if (mar_we) mar_q <= sum;
    end
  end
endmodule

// File: rtl/pc_addr_unit_chk.sv
module pc_addr_unit_chk #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16,
  parameter int STEP  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pc_ld,
  input logic             mar_ld,
  input logic             use_offset,
  input logic [OFS_W-1:0] ir_offset,
  input logic [XLEN-1:0]  pc_q,
  input logic [XLEN-1:0]  mar_q
);
  logic [XLEN-1:0] ofs_c;
  assign ofs_c = {{(XLEN-OFS_W){ir_offset[OFS_W-1]}}, ir_offset};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && mar_q == '0));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (pc_ld && !use_offset) |=> pc_q == $past(pc_q) + XLEN'(STEP));

  assert_mar_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (mar_ld && !pc_ld && use_offset) |=> (mar_q == $past(pc_q) + $past(ofs_c)) && $stable(pc_q));

  assert_pc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !pc_ld |=> $stable(pc_q));

  assert_mar_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !mar_ld |=> $stable(mar_q));

  assert_pc_priority_R6: assert property (@(posedge clk) disable iff (rst)
    (pc_ld && mar_ld) |=> $stable(mar_q));

  assert_pc_branch_R8: assert property (@(posedge clk) disable iff (rst)
    (pc_ld && use_offset) |=> pc_q == $past(pc_q) + $past(ofs_c));
endmodule

bind pc_addr_unit pc_addr_unit_chk u_chk (
  .clk(clk), .rst(rst), .pc_ld(pc_ld), .mar_ld(mar_ld),
  .use_offset(use_offset), .ir_offset(ir_offset),
  .pc_q(pc_q), .mar_q(mar_q)
);

// File: tb/pc_addr_unit_bench.sv
module pc_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pc_ld = 1'b0;
  logic        mar_ld = 1'b0;
  logic        use_offset = 1'b0;
  logic [15:0] ir_offset = '0;
  logic [31:0] pc_q, mar_q;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] mar;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] m_pc = '0;
  logic [31:0] m_mar = '0;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pc_addr_unit u_pc_addr_unit (
    .clk(clk), .rst(rst), .pc_ld(pc_ld), .mar_ld(mar_ld),
    .use_offset(use_offset), .ir_offset(ir_offset),
    .pc_q(pc_q), .mar_q(mar_q)
  );

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; pc_ld = 1'b0; mar_ld = 1'b0;
    m_pc = '0; m_mar = '0;
    sb.push_back('{m_pc, m_mar, tag});
  endtask

  task automatic step(input bit pl, input bit ml, input bit sel,
                      input logic [15:0] ofs, input string tag);
    logic [31:0] opnd;
    logic [31:0] s;
    @(negedge clk);
    rst = 1'b0; pc_ld = pl; mar_ld = ml; use_offset = sel; ir_offset = ofs;
    opnd = sel ? {{16{ofs[15]}}, ofs} : 32'd4;
    s = m_pc + opnd;
    if (ml && !pl) m_mar = s;
    if (pl) m_pc = s;
    sb.push_back('{m_pc, m_mar, tag});
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_vec++;
      if (pc_q !== e.pc || mar_q !== e.mar) begin
        n_bad++;
        $display("FAIL %s pc=%h exp=%h mar=%h exp=%h", e.tag, pc_q, e.pc, mar_q, e.mar);
      end
    end
  end

  initial begin
    do_reset("R1 initial reset");
    step(0, 0, 0, 16'h0000, "R5 idle hold");
    step(1, 0, 0, 16'h0000, "R2 step by 4");
    step(1, 0, 0, 16'h0000, "R2 second step");
    step(0, 1, 1, 16'h0010, "R3 positive offset");
    step(0, 1, 1, 16'hFFF0, "R4 negative offset");
    step(0, 0, 1, 16'h1234, "R5 offset ignored when idle");
    step(1, 1, 0, 16'h0000, "R6 both loads step");
    step(1, 1, 1, 16'h0100, "R6 both loads offset");
    step(1, 0, 1, 16'h8000, "R8 pc plus negative offset");
    step(0, 1, 0, 16'h0000, "R3 address with constant operand");
    do_reset("R1 reset from nonzero");
    step(1, 0, 1, 16'hFFFC, "R8 pc to top");
    step(1, 0, 0, 16'h0000, "R7 wrap to zero");
    step(0, 1, 1, 16'h7FFF, "R3 max positive offset");
    step(0, 1, 1, 16'hFFFF, "R7 all ones");
    step(0, 0, 0, 16'h0000, "R5 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule